// File: doc/BRIEF.md
# DMA interrupt coalescing unit

This block produces the completion interrupts of one DMA channel. Every finished transfer arrives as a one-cycle completion pulse. Instead of interrupting on each transfer, the block counts completions down from a threshold held in the control word. When the count runs out, it raises a completion-interrupt status bit. A delay timer is also loaded from the control word, and every completion loads it again and restarts it. If no further completion arrives before the timer runs down, a separate delay-interrupt status bit is raised. This way, completions that never reach the threshold are still reported.

The block also takes a channel-start pulse, which reloads the counter, and a fault pulse that sets a third status bit. Software clears pending bits by writing ones to the status word. The readback word places the live timer and counter next to the pending bits. A single interrupt line is the registered OR of the pending bits that the control word enables. The timer counts down on a prescaled tick, whose divide ratio is a parameter.

Top module: `irq_coalesce_unit`

## Requirements
- R1: After reset the pending bits are 0, the completion counter holds 1, the timer holds 0 and `irq_o` is 0.
- R2: A completion pulse with no start pulse decrements the counter. When the counter holds 1 or 0 at that pulse, pending bit 12 (completion interrupt) is set and the counter reloads from control bits 23:16.
- R3: A completion pulse loads the timer with control bits 31:24 and restarts the prescaler. After that the timer drops by one every TICK_DIV cycles. The step from 1 to 0 sets pending bit 13 (delay interrupt) and reloads the counter from control bits 23:16. A completion in the same cycle cancels that expiry.
- R4: A status write clears each of pending bits 14:12 whose write-data bit is 1. A zero in those bits, and every other bit of the write data, leaves the state unchanged.
- R5: `irq_o` equals the OR of pending bits 14:12 ANDed with control bits 14:12, as registered one cycle after the pending bits or enables change.
- R6: A start pulse loads the counter from control bits 23:16 and takes priority over a completion in the same cycle.
- R7: A delay value of 0 leaves the timer at 0, and no delay interrupt follows.
- R8: A fault pulse sets pending bit 14.
- R9: The status readback word carries the timer in bits 31:24, the counter in bits 23:16 and the pending bits in 14:12. All other bits are 0.
- R10: When a pending bit is set and cleared in the same cycle, it ends up set.
- R11: A threshold of 0 acts as 1: every completion sets pending bit 12 and the counter stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmpl_pulse_i | input | 1 | One-cycle pulse per completed transfer |
| run_start_i | input | 1 | One-cycle pulse when the channel is started |
| fault_pulse_i | input | 1 | One-cycle pulse that sets the fault pending bit |
| ctrl_word_i | input | 32 | Control word: delay 31:24, threshold 23:16, enables 14:12 |
| stat_wr_i | input | 1 | Status write strobe |
| stat_wdata_i | input | 32 | Status write data; ones in 14:12 clear pending bits |
| stat_word_o | output | 32 | Readback: timer 31:24, counter 23:16, pending 14:12 |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The bench builds the block with TICK_DIV set to 2. At that ratio a full delay expiry takes a few cycles per timer step, so several expiries and restarts fit into a short run. The ratio of 2 also makes the prescaler-restart timing visible, which a ratio of 1 would hide. The bench checks the exact cycle in which the timer reaches 1 and the next cycle, in which it expires. Further cases are a restart in the middle of a countdown, a zero threshold, a zero delay, and set-versus-clear collisions.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int FLD_W    = 8;
    localparam int THR_LSB  = 16;
    localparam int DLY_LSB  = 24;
    localparam int PEND_LSB = 12;
    localparam int NSRC     = 3;

    // Pending / enable vector; bit order follows bits 14:12.
    typedef struct packed {
        logic fault;   // bit 14
        logic delay;   // bit 13
        logic cmpl;    // bit 12
    } irq_src_t;

    // Readback word layout.
    typedef struct packed {
        logic [FLD_W-1:0] tmr;    // 31:24
        logic [FLD_W-1:0] cnt;    // 23:16
        logic             rsv_hi; // 15
        irq_src_t         pend;   // 14:12
        logic [11:0]      rsv_lo; // 11:0
    } stat_word_t;

    function automatic logic [FLD_W-1:0] ctrl_thr(input logic [31:0] c);
        return c[THR_LSB +: FLD_W];
    endfunction

    function automatic logic [FLD_W-1:0] ctrl_dly(input logic [31:0] c);
        return c[DLY_LSB +: FLD_W];
    endfunction

    function automatic irq_src_t src_field(input logic [31:0] w);
        return irq_src_t'(w[PEND_LSB +: NSRC]);
    endfunction

endpackage

// File: rtl/irqc_prescaler.sv
module irqc_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick_o = (phase_q == LAST);
endmodule

// File: rtl/irqc_delay_timer.sv
module irqc_delay_timer
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [FLD_W-1:0] load_val_i,
    input  logic             tick_i,
    output logic [FLD_W-1:0] tmr_o,
    output logic             expire_o
);
    logic [FLD_W-1:0] tmr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '0;
        end else if (load_i) begin
            tmr_q <= load_val_i;
        end else if (tick_i && (tmr_q != '0)) begin
            tmr_q <= tmr_q - 1'b1;
        end
    end

    // A load in the same cycle restarts the countdown instead.
    assign expire_o = tick_i && !load_i && (tmr_q == FLD_W'(1));
    assign tmr_o    = tmr_q;
endmodule

// File: rtl/irqc_cmpl_counter.sv
module irqc_cmpl_counter
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             cmpl_i,
    input  logic             expire_i,
    input  logic [FLD_W-1:0] thr_i,
    output logic [FLD_W-1:0] cnt_o,
    output logic             hit_o
);
    logic [FLD_W-1:0] cnt_q;
    logic             last;

    assign last  = (cnt_q <= FLD_W'(1));
    assign hit_o = cmpl_i && !start_i && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= FLD_W'(1);
        end else if (start_i) begin
            cnt_q <= thr_i;
        end else if (cmpl_i) begin
            cnt_q <= last ? thr_i : cnt_q - 1'b1;
        end else if (expire_i) begin
            cnt_q <= thr_i;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/irqc_status.sv
module irqc_status
    import irqc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  irq_src_t set_i,
    input  irq_src_t clr_i,
    input  irq_src_t en_i,
    output irq_src_t pend_o,
    output logic     irq_o
);
    irq_src_t pend_q;
    logic     irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            // Set beats clear so no event is lost.
            pend_q <= irq_src_t'((pend_q & ~clr_i) | set_i);
            irq_q  <= |(pend_q & en_i);
        end
    end

    assign pend_o = pend_q;
    assign irq_o  = irq_q;
endmodule

// File: rtl/irq_coalesce_unit.sv
module irq_coalesce_unit
    import irqc_pkg::*;
#(
    parameter int TICK_DIV = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmpl_pulse_i,
    input  logic        run_start_i,
    input  logic        fault_pulse_i,
    input  logic [31:0] ctrl_word_i,
    input  logic        stat_wr_i,
    input  logic [31:0] stat_wdata_i,
    output logic [31:0] stat_word_o,
    output logic        irq_o
);
    logic             tick;
    logic             expire;
    logic             hit;
    logic [FLD_W-1:0] tmr;
    logic [FLD_W-1:0] cnt;
    irq_src_t         set_v;
    irq_src_t         clr_v;
    irq_src_t         pend;
    stat_word_t       word;
    logic             unused_bits;

    assign unused_bits = ^{ctrl_word_i[PEND_LSB-1:0], ctrl_word_i[THR_LSB-1],
                           stat_wdata_i[31:PEND_LSB+NSRC], stat_wdata_i[PEND_LSB-1:0]};

    irqc_prescaler #(.DIV(TICK_DIV)) i_presc (
        .clk       (clk),
        .rst       (rst),
        .restart_i (cmpl_pulse_i),
        .tick_o    (tick)
    );

    irqc_delay_timer i_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (cmpl_pulse_i),
        .load_val_i (ctrl_dly(ctrl_word_i)),
        .tick_i     (tick),
        .tmr_o      (tmr),
        .expire_o   (expire)
    );

    irqc_cmpl_counter i_cnt (
        .clk      (clk),
        .rst      (rst),
        .start_i  (run_start_i),
        .cmpl_i   (cmpl_pulse_i),
        .expire_i (expire),
        .thr_i    (ctrl_thr(ctrl_word_i)),
        .cnt_o    (cnt),
        .hit_o    (hit)
    );

    always_comb begin
        set_v       = '0;
        set_v.cmpl  = hit;
        set_v.delay = expire;
        set_v.fault = fault_pulse_i;
        clr_v       = stat_wr_i ? src_field(stat_wdata_i) : '0;
    end

    irqc_status i_stat (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_v),
        .clr_i  (clr_v),
        .en_i   (src_field(ctrl_word_i)),
        .pend_o (pend),
        .irq_o  (irq_o)
    );

    always_comb begin
        word      = '0;
        word.tmr  = tmr;
        word.cnt  = cnt;
        word.pend = pend;
    end

    assign stat_word_o = word;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker (
    input logic       clk,
    input logic       rst,
    input logic       cmpl_i,
    input logic       start_i,
    input logic       wr_i,
    input logic [2:0] clr_i,
    input logic [7:0] thr_i,
    input logic [7:0] dly_i,
    input logic [2:0] en_i,
    input logic [2:0] pend_i,
    input logic [7:0] cnt_i,
    input logic [7:0] tmr_i,
    input logic       irq_i
);
    // R5: line follows enabled pending bits one cycle later
    assert_irq_follows_R5: assert property (@(posedge clk) disable iff (rst)
        irq_i == $past(|(pend_i & en_i)));

    // R2: completion at count 1 or 0 sets bit 12
    assert_cnt_hit_R2: assert property (@(posedge clk) disable iff (rst)
        (cmpl_i && !start_i && (cnt_i <= 8'd1)) |=> pend_i[0]);

    // R6: start reloads the counter
    assert_start_reload_R6: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (cnt_i == $past(thr_i)));

    // R3: completion loads the timer
    assert_tmr_load_R3: assert property (@(posedge clk) disable iff (rst)
        cmpl_i |=> (tmr_i == $past(dly_i)));

    // R3: without a completion the timer never rises
    assert_tmr_monotone_R3: assert property (@(posedge clk) disable iff (rst)
        !cmpl_i |=> (tmr_i <= $past(tmr_i)));

    // R7: an idle timer raises no delay interrupt
    assert_no_delay_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (tmr_i == 8'd0) |=> !$rose(pend_i[1]));

    // R4: a pending bit only falls after a write of one
    for (genvar b = 0; b < 3; b++) begin : g_w1c
        assert_w1c_only_R4: assert property (@(posedge clk) disable iff (rst)
            $fell(pend_i[b]) |-> $past(wr_i && clr_i[b]));
    end
endmodule

bind irq_coalesce_unit irqc_checker i_chk (
    .clk     (clk),
    .rst     (rst),
    .cmpl_i  (cmpl_pulse_i),
    .start_i (run_start_i),
    .wr_i    (stat_wr_i),
    .clr_i   (stat_wdata_i[14:12]),
    .thr_i   (ctrl_word_i[23:16]),
    .dly_i   (ctrl_word_i[31:24]),
    .en_i    (ctrl_word_i[14:12]),
    .pend_i  (stat_word_o[14:12]),
    .cnt_i   (stat_word_o[23:16]),
    .tmr_i   (stat_word_o[31:24]),
    .irq_i   (irq_o)
);

// File: tb/test_irq_coalesce_unit.sv
module test_irq_coalesce_unit;
    localparam int TICK_DIV = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmpl_p = 1'b0;
    logic        start_p = 1'b0;
    logic        fault_p = 1'b0;
    logic [31:0] ctrl = 32'h0;
    logic        wr = 1'b0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] stat;
    logic        irq;

    always #10 clk = ~clk;  // 50 MHz

    irq_coalesce_unit #(.TICK_DIV(TICK_DIV)) i_irq_coalesce_unit (
        .clk           (clk),
        .rst           (rst),
        .cmpl_pulse_i  (cmpl_p),
        .run_start_i   (start_p),
        .fault_pulse_i (fault_p),
        .ctrl_word_i   (ctrl),
        .stat_wr_i     (wr),
        .stat_wdata_i  (wdata),
        .stat_word_o   (stat),
        .irq_o         (irq)
    );

    typedef struct {
        string       tag;
        logic [31:0] stat;
        logic        irq;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk = 0;
    int   n_err = 0;
    bit   fin = 1'b0;

    function automatic logic [31:0] mk_ctrl(int dly, int thr, logic [2:0] en);
        return (32'(dly) << 24) | (32'(thr) << 16) | (32'(en) << 12);
    endfunction

    function automatic logic [31:0] mk_stat(int tmr, int cnt, logic [2:0] p);
        return (32'(tmr) << 24) | (32'(cnt) << 16) | (32'(p) << 12);
    endfunction

    // Driver side: push expected item for the current cycle.
    task automatic expect_now(string tag, logic [31:0] s, logic i);
        exp_t e;
        e.tag  = tag;
        e.stat = s;
        e.irq  = i;
        sb_q.push_back(e);
    endtask

    // Called at a negedge; holds inputs across one posedge.
    task automatic apply(logic d, logic s, logic f, logic w, logic [31:0] wd);
        cmpl_p  = d;
        start_p = s;
        fault_p = f;
        wr      = w;
        wdata   = wd;
        @(negedge clk);
        cmpl_p  = 1'b0;
        start_p = 1'b0;
        fault_p = 1'b0;
        wr      = 1'b0;
        wdata   = 32'h0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare against the scoreboard away from the clock edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_chk++;
                if (stat !== e.stat || irq !== e.irq) begin
                    n_err++;
                    $display("FAIL %s: stat=%h irq=%b expected stat=%h irq=%b",
                             e.tag, stat, irq, e.stat, e.irq);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!fin) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        ctrl = mk_ctrl(0, 1, 3'b000);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        expect_now("R1 reset state", mk_stat(0, 1, 3'b000), 1'b0);

        // Threshold 3, completion interrupt enabled
        ctrl = mk_ctrl(0, 3, 3'b001);
        apply(0, 1, 0, 0, 0);
        expect_now("R6 start reloads count", mk_stat(0, 3, 3'b000), 1'b0);
        apply(1, 0, 0, 0, 0);
        expect_now("R2 count 3->2", mk_stat(0, 2, 3'b000), 1'b0);
        apply(1, 0, 0, 0, 0);
        expect_now("R2 count 2->1", mk_stat(0, 1, 3'b000), 1'b0);
        apply(1, 0, 0, 0, 0);
        expect_now("R2 hit sets bit12, reload", mk_stat(0, 3, 3'b001), 1'b0);
        idle(1);
        expect_now("R5 irq one cycle later", mk_stat(0, 3, 3'b001), 1'b1);

        // Write one to clear
        apply(0, 0, 0, 1, 32'hFFFF_2FFF);
        expect_now("R4 zero in bit12 and other bits ignored", mk_stat(0, 3, 3'b001), 1'b1);
        apply(0, 0, 0, 1, 32'h0000_1000);
        expect_now("R4 one clears bit12", mk_stat(0, 3, 3'b000), 1'b1);
        idle(1);
        expect_now("R5 irq falls after clear", mk_stat(0, 3, 3'b000), 1'b0);

        // Delay timer 4, delay interrupt enabled
        ctrl = mk_ctrl(4, 3, 3'b010);
        apply(1, 0, 0, 0, 0);
        expect_now("R9 timer and count fields", mk_stat(4, 2, 3'b000), 1'b0);
        idle(7);
        expect_now("R3 timer at 1 before expiry", mk_stat(1, 2, 3'b000), 1'b0);
        idle(1);
        expect_now("R3 expiry sets bit13, reloads count", mk_stat(0, 3, 3'b010), 1'b0);
        idle(1);
        expect_now("R5 delay irq", mk_stat(0, 3, 3'b010), 1'b1);

        apply(0, 0, 0, 1, 32'h0000_2000);
        expect_now("R4 clear bit13", mk_stat(0, 3, 3'b000), 1'b1);
        idle(1);
        expect_now("R5 irq low", mk_stat(0, 3, 3'b000), 1'b0);

        // Restart mid countdown
        apply(1, 0, 0, 0, 0);
        expect_now("R3 load", mk_stat(4, 2, 3'b000), 1'b0);
        idle(5);
        expect_now("R3 counting down", mk_stat(2, 2, 3'b000), 1'b0);
        apply(1, 0, 0, 0, 0);
        expect_now("R3 restart reloads timer", mk_stat(4, 1, 3'b000), 1'b0);
        idle(7);
        expect_now("R3 restarted timer at 1", mk_stat(1, 1, 3'b000), 1'b0);
        idle(1);
        expect_now("R3 restarted expiry", mk_stat(0, 3, 3'b010), 1'b0);
        idle(1);
        expect_now("R5 irq after restarted expiry", mk_stat(0, 3, 3'b010), 1'b1);

        // Delay 0 disables the timer
        apply(0, 0, 0, 1, 32'h0000_2000);
        expect_now("R4 clear bit13 again", mk_stat(0, 3, 3'b000), 1'b1);
        ctrl = mk_ctrl(0, 2, 3'b010);
        apply(1, 0, 0, 0, 0);
        expect_now("R7 zero delay loads 0", mk_stat(0, 2, 3'b000), 1'b0);
        idle(20);
        expect_now("R7 no delay interrupt", mk_stat(0, 2, 3'b000), 1'b0);

        // Masked pending bit
        ctrl = mk_ctrl(0, 2, 3'b000);
        apply(1, 0, 0, 0, 0);
        expect_now("R2 count 2->1", mk_stat(0, 1, 3'b000), 1'b0);
        apply(1, 0, 0, 0, 0);
        expect_now("R2 hit with threshold 2", mk_stat(0, 2, 3'b001), 1'b0);
        idle(2);
        expect_now("R5 masked bit gives no irq", mk_stat(0, 2, 3'b001), 1'b0);
        ctrl = mk_ctrl(0, 2, 3'b001);
        idle(1);
        expect_now("R5 enabling raises irq", mk_stat(0, 2, 3'b001), 1'b1);

        // Set and clear in the same cycle
        apply(1, 0, 0, 0, 0);
        expect_now("R2 count to 1", mk_stat(0, 1, 3'b001), 1'b1);
        apply(1, 0, 0, 1, 32'h0000_1000);
        expect_now("R10 set wins over clear", mk_stat(0, 2, 3'b001), 1'b1);
        apply(0, 0, 0, 1, 32'h0000_1000);
        expect_now("R4 clear after collision", mk_stat(0, 2, 3'b000), 1'b1);
        idle(1);
        expect_now("R5 irq low", mk_stat(0, 2, 3'b000), 1'b0);

        // Fault bit
        ctrl = mk_ctrl(0, 2, 3'b100);
        apply(0, 0, 1, 0, 0);
        expect_now("R8 fault sets bit14", mk_stat(0, 2, 3'b100), 1'b0);
        idle(1);
        expect_now("R8 fault irq", mk_stat(0, 2, 3'b100), 1'b1);
        apply(0, 0, 0, 1, 32'h0000_4000);
        expect_now("R4 clear bit14", mk_stat(0, 2, 3'b000), 1'b1);

        // Start beats completion
        ctrl = mk_ctrl(0, 5, 3'b000);
        apply(1, 1, 0, 0, 0);
        expect_now("R6 start has priority", mk_stat(0, 5, 3'b000), 1'b0);

        // Threshold 0
        ctrl = mk_ctrl(0, 0, 3'b001);
        apply(0, 1, 0, 0, 0);
        expect_now("R11 start with threshold 0", mk_stat(0, 0, 3'b000), 1'b0);
        apply(1, 0, 0, 0, 0);
        expect_now("R11 every completion hits", mk_stat(0, 0, 3'b001), 1'b0);
        apply(0, 0, 0, 1, 32'h0000_1000);
        expect_now("R4 clear", mk_stat(0, 0, 3'b000), 1'b1);
        apply(1, 0, 0, 0, 0);
        expect_now("R11 second hit", mk_stat(0, 0, 3'b001), 1'b0);

        idle(2);
        fin = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule